// File: doc/BRIEF.md
# Microcode Fetch Sequencer Without Branch Bubble

This block is the front end of a microcoded processor. It hands the decode stage a fresh control item on every cycle after reset. An item is either an opcode, held in the instruction register, or a microinstruction word, held in the microinstruction register. When reset is released, the block makes up a break opcode (0x00) and does not read memory for it. From then on, each opcode is followed by its microinstructions, one per cycle. They are read from a small computed test microprogram at address {opcode, step}.

The last microinstruction of each routine carries a fetch-opcode bit. In the cycle that word sits in decode, the block raises `op_fetch` and captures `mem_data` at the next clock edge. The microinstruction that the fetch stage read in that same cycle belongs to the old routine, so it is dropped. The new opcode takes its slot. Decode therefore sees no empty cycle at an opcode boundary.

Each word holds the execute operation for the current step and also the operand-source and recirculate selects for the next step.

Top module: `useq_front`

## Requirements
- R1: While `rst_n` is low, `dec_valid` and `op_fetch` are both 0.
- R2: The first cycle in which `dec_valid` is high after reset is an opcode cycle: `dec_opcode`=1, `dec_ir`=0x00 and `dec_word`=0, with no memory fetch.
- R3: `op_fetch` is high exactly in those valid cycles where decode holds a microinstruction with bit 8 (fetch-opcode) set. In every other cycle it is low.
- R4: The cycle after `op_fetch` is an opcode cycle. In it, `dec_ir` equals the `mem_data` value captured at the clock edge that ended the fetch cycle, `dec_opcode`=1 and `dec_word`=0.
- R5: After an opcode cycle, decode receives the microinstructions for steps 1 to n in order, one per cycle, with `dec_opcode`=0. The routine length is n = `dec_ir`[1:0]+1, and the fetch bit is set only at step n.
- R6: The test microinstruction for opcode o and step s is built as follows:
  - bit 8: (s == o[1:0]+1)
  - bits 7:5: o[2:0] XOR s
  - bits 4:3: next A-operand source, equal to o[4:3]
  - bits 2:1: next B-operand source, equal to s[1:0]
  - bit 0: recirculate, equal to o[5] XOR s[0]
- R7: Once `dec_valid` rises it stays high until the next reset. An opcode whose routine has n steps occupies exactly n+1 decode cycles.
- R8: `mem_data` has no effect when `op_fetch` is low. `dec_ir` changes only in the cycle that follows a fetch or a reset.
- R9: A reset asserted in the middle of a routine abandons that routine. Operation restarts with the break opcode as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_data | input | 8 | Opcode byte from memory; sampled only when `op_fetch` is high |
| op_fetch | output | 1 | Opcode fetch in progress; memory must present the next opcode |
| dec_valid | output | 1 | Decode holds a valid item |
| dec_opcode | output | 1 | Decode item is an opcode (1) or a microinstruction (0) |
| dec_ir | output | 8 | Instruction register |
| dec_word | output | 9 | Microinstruction register (zero during an opcode cycle) |

## Verification
The bench drives noise on `mem_data` whenever no fetch is in progress. A design that samples the bus at the wrong moment therefore loads a garbage opcode, and the scoreboard reports a wrong `dec_ir`.

Routines of every length from one to four steps are run back to back. A design that inserted a bubble at the boundary would show `dec_valid` low or shift every later item by one cycle. A design that kept the discarded fetch-slot word would show a stray old-routine word where the opcode belongs.

A reset in the middle of a routine must bring back the break opcode. It must not resume at the old step, and it must not present a stale word.

// File: rtl/useq_front.sv
`timescale 1ns/1ps
module useq_front #(
  parameter int OPW = 8,
  parameter int STW = 3,
  parameter int LENB = 2,
  parameter logic [OPW-1:0] BRK_OP = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPW-1:0]   mem_data,
  output logic             op_fetch,
  output logic             dec_valid,
  output logic             dec_opcode,
  output logic [OPW-1:0]   dec_ir,
  output logic [8:0]       dec_word
);
  localparam int CWW = 9;
  localparam int FBIT = CWW - 1;

  logic           valid_q, is_op;
  logic [OPW-1:0] ir;
  logic [STW-1:0] step;
  logic [CWW-1:0] mir;

  // test microprogram: execute op now, operand setup for the next step
  function automatic logic [CWW-1:0] urom(input logic [OPW-1:0] op, input logic [STW-1:0] st);
    logic [2:0] s3;
    s3 = 3'(st);
    urom = {st == (STW'(op[LENB-1:0]) + STW'(1)), op[2:0] ^ s3, op[4:3], s3[1:0], op[5] ^ s3[0]};
  endfunction

  assign op_fetch   = valid_q & ~is_op & mir[FBIT];
  assign dec_valid  = valid_q;
  assign dec_opcode = is_op;
  assign dec_ir     = ir;
  assign dec_word   = mir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      is_op   <= 1'b0;
      ir      <= BRK_OP;
      step    <= '0;
      mir     <= '0;
    end else if (!valid_q) begin
      valid_q <= 1'b1;
      is_op   <= 1'b1;
      ir      <= BRK_OP;
      step    <= STW'(1);
      mir     <= '0;
    end else if (op_fetch) begin
      is_op   <= 1'b1;
      ir      <= mem_data;
      step    <= STW'(1);
      mir     <= '0;
    end else begin
      is_op   <= 1'b0;
      mir     <= urom(ir, step);
      step    <= step + STW'(1);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> (!dec_valid && !op_fetch));
  assert_boot_brk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> (dec_opcode && dec_ir == BRK_OP));
  assert_fetch_then_opcode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_fetch |=> (dec_opcode && dec_word == '0));
  assert_opcode_then_micro_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_opcode) |=> !dec_opcode);
  assert_no_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> dec_valid);
  assert_ir_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !op_fetch) |=> $stable(dec_ir));
endmodule

// File: tb/sim_useq_front.sv
`timescale 1ns/1ps
module sim_useq_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] mem_data;
  logic op_fetch, dec_valid, dec_opcode;
  logic [7:0] dec_ir;
  logic [8:0] dec_word;

  logic [7:0] prog [0:15];
  int nprog = 0, idx = 0, errs = 0, checks = 0, cyc = 0;
  bit mon_en = 0, prev_fetch = 0, first = 0;
  logic [7:0] noise = 8'h5A;
  logic [17:0] q[$];

  always #2.5 clk = ~clk;

  assign mem_data = op_fetch ? ((idx < nprog) ? prog[idx] : 8'h00) : noise;

  useq_front u0 (.clk(clk), .rst_n(rst_n), .mem_data(mem_data), .op_fetch(op_fetch),
    .dec_valid(dec_valid), .dec_opcode(dec_opcode), .dec_ir(dec_ir), .dec_word(dec_word));

  function automatic logic [8:0] uw(input logic [7:0] op, input logic [2:0] s);
    uw = {s == ({1'b0, op[1:0]} + 3'd1), op[2:0] ^ s, op[4:3], s[1:0], op[5] ^ s[0]};
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic push_op(input logic [7:0] op);
    q.push_back({1'b1, op, 9'd0});
    for (int s = 1; s <= op[1:0] + 1; s++) q.push_back({1'b0, op, uw(op, 3'(s))});
  endtask

  // monitor: pops expected items and compares each decode cycle
  always @(negedge clk) begin
    logic [17:0] e;
    noise = {noise[6:0], noise[7] ^ noise[5]} + 8'h3B;
    if (mon_en) begin
      if (prev_fetch) idx++;
      prev_fetch = op_fetch;
      if (q.size() > 0) begin
        chk(dec_valid, "R7 no gap", 32'(dec_valid), 32'd1);
        e = q.pop_front();
        if (e[17]) chk({dec_opcode, dec_ir, dec_word} == e, first ? "R2 R9 boot opcode" : "R4 opcode slot",
                       32'({dec_opcode, dec_ir, dec_word}), 32'(e));
        else chk({dec_opcode, dec_ir, dec_word} == e, "R5 R6 R8 microword",
                 32'({dec_opcode, dec_ir, dec_word}), 32'(e));
        chk(op_fetch == (!e[17] && e[8]), "R3 fetch strobe", 32'(op_fetch), 32'(!e[17] && e[8]));
        first = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic run_phase();
    @(posedge clk) #1 rst_n = 1'b1;
    @(posedge clk) #1 begin first = 1; mon_en = 1; end
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!dec_valid && !op_fetch, "R1 reset", 32'({dec_valid, op_fetch}), 32'd0);
    prog[0] = 8'h03; prog[1] = 8'h01; prog[2] = 8'hA6; prog[3] = 8'h3F;
    prog[4] = 8'h00; prog[5] = 8'hFF; prog[6] = 8'h5C; prog[7] = 8'h02;
    nprog = 8; idx = 0; prev_fetch = 0;
    push_op(8'h00);
    for (int i = 0; i < 8; i++) push_op(prog[i]);
    run_phase();
    // R9: reset in mid routine
    repeat (2) @(negedge clk);
    mon_en = 0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(!dec_valid && !op_fetch, "R1 R9 reset mid routine", 32'({dec_valid, op_fetch}), 32'd0);
    q.delete();
    prog[0] = 8'h07; prog[1] = 8'h12; prog[2] = 8'h9D; prog[3] = 8'h40;
    nprog = 4; idx = 0; prev_fetch = 0;
    push_op(8'h00);
    for (int i = 0; i < 4; i++) push_op(prog[i]);
    run_phase();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule